// File: doc/BRIEF.md
# Multi-Output Raster Sync Generator

This block is a free-running raster timing source for a display pipeline. A horizontal counter steps through the pixel clocks of one line. A vertical counter steps through the lines of one field. The field length is programmed in half-lines, so a progressive frame of N lines is set up as 2N.

From the two counters the block derives an active-video window flag and four separately programmed sync lanes. Each lane has its own horizontal sync edges and its own vertical sync edges, so every downstream path can be given a sync that matches its own pipeline delay. Both kinds of pulse may wrap: a horizontal pulse can wrap across the line end, and a vertical pulse can wrap across the frame end. Vertical edges are placed at a line and a pixel offset within that line, so vertical sync can change in the middle of a line.

A single-cycle field event marks the first sample of every field, for use by an interrupt block. Only progressive timing is generated. Every field is a top field, and the bottom-field registers are storage only.

Top module: `raster_sync_gen`

## Requirements
- R1: While and after reset the position is line 1, pixel 0; the line length is H_DEF (16), the field length is VH_DEF (16 half-lines), and mode, window and all sync registers are zero. With those values active, every hsync and every vsync are low, and field_evt is high.
- R2: The pixel counter runs 0 .. L-1 and wraps to 0, where L is the line length. The line counter runs 1 .. F/2 and then wraps to 1, where F is the programmed half-line count.
- R3: A horizontal edge register holds the start pixel in bits 15:0 and the stop pixel in bits 31:16. hsync is high for pixels p with start <= p < stop. When start > stop the pulse wraps across the line end (p >= start or p < stop). When start equals stop, hsync stays low.
- R4: The top vertical line register holds the rise line in bits 15:0 and the fall line in bits 31:16. The top vertical offset register holds the rise pixel in bits 15:0 and the fall pixel in bits 31:16. vsync is high from position (rise line, rise pixel) inclusive up to (fall line, fall pixel) exclusive, in raster order. The pulse wraps across the frame end when the rise position comes after the fall position.
- R5: The four lanes are independent. Writing one lane's registers changes only that lane's hsync and vsync bits.
- R6: The top window start and stop registers each hold a line in bits 31:16 and a pixel in bits 15:0. active is high when the line lies between the two lines and the pixel lies between the two pixels, both bounds inclusive.
- R7: field_evt is high exactly while the block is running and the position is line 1, pixel 0. With L > 1 this makes it a single-cycle pulse at each field start.
- R8: A written line length, field length or top window takes effect only at a frame wrap (the edge leaving the last pixel of the last line) or at a restart. Until then the previous values keep governing counting and active.
- R9: A write with bit 0 set to the restart address puts the position at line 1, pixel 0 on that same clock edge and loads the pending values of R8. A restart write with bit 0 clear has no effect.
- R10: Mode value 0 runs the counters. Any other mode value freezes the counters at their position from the edge after the write and holds field_evt low. Writing 0 resumes counting from the frozen position.
- R11: Writes to the bottom window registers and the bottom vertical line and offset registers are stored but never change active, hsync or vsync.
- R12: A write is taken on a clock edge with wr_en high, at word address wr_addr. The addresses are: mode 0x00, line length 0x01, half-line count 0x02, restart 0x03, top window start 0x04, top window stop 0x05, bottom window start 0x06, bottom window stop 0x07. Lane k uses base 0x10 + 8k, with offsets +0 horizontal edges, +1 top vertical lines, +2 bottom vertical lines, +3 top vertical offsets, +4 bottom vertical offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Register word address |
| wr_data | input | 2*CW (32) | Register write data |
| hsync | output | NUM_SYNC (4) | Horizontal sync, one bit per lane |
| vsync | output | NUM_SYNC (4) | Vertical sync, one bit per lane |
| active | output | 1 | Inside the active-video window |
| field_evt | output | 1 | Field start event |

## Verification
The bench runs through a series of programming patterns and compares all outputs every cycle against a model of the requirements.

- **Sync placement.** Horizontal pulses are tried in three forms: non-wrapping, wrapping across the line end, and zero-width. These separate a correct ordered-span comparison from one that ignores wrap or equality. Vertical pulses are tried both inside one frame with mid-line offsets and wrapping across the frame end, which tells a two-level (line then pixel) comparison from one that looks at line numbers alone.
- **Shadowing.** Line and field lengths are changed in the middle of a frame, which exposes any change that is applied at once instead of at the next frame wrap.
- **Modes, restart and bottom registers.** Freeze and resume, restart with bit 0 set and with it clear, and bottom-register writes each isolate one control path.

// File: rtl/raster_sync_pkg.sv
package raster_sync_pkg;

    // Word addresses of the global registers
    localparam int unsigned ADDR_MODE    = 'h00;
    localparam int unsigned ADDR_HLEN    = 'h01;
    localparam int unsigned ADDR_VHALF   = 'h02;
    localparam int unsigned ADDR_RESTART = 'h03;
    localparam int unsigned ADDR_WIN_TLO = 'h04;
    localparam int unsigned ADDR_WIN_THI = 'h05;
    localparam int unsigned ADDR_WIN_BLO = 'h06;
    localparam int unsigned ADDR_WIN_BHI = 'h07;

    // Per-lane register group placement
    localparam int unsigned SYNC_BASE   = 'h10;
    localparam int unsigned SYNC_STRIDE = 8;
    localparam int unsigned SYNC_REGS   = 5;

    // Register index inside one lane group
    localparam int unsigned SREG_HEDGE     = 0;
    localparam int unsigned SREG_VLINE_TOP = 1;
    localparam int unsigned SREG_VLINE_BOT = 2;
    localparam int unsigned SREG_VOFF_TOP  = 3;
    localparam int unsigned SREG_VOFF_BOT  = 4;

endpackage

// File: rtl/raster_sync_regs.sv
module raster_sync_regs
    import raster_sync_pkg::*;
#(
    parameter int CW       = 16,
    parameter int NUM_SYNC = 4,
    parameter int AW       = 8,
    parameter int H_DEF    = 16,
    parameter int VH_DEF   = 16,
    localparam int DW      = 2 * CW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [DW-1:0]                 wr_data,
    output logic                          run,
    output logic                          restart,
    output logic [CW-1:0]                 hlen_live,
    output logic [CW-1:0]                 vhalf_live,
    output logic [DW-1:0]                 win_lo_live,
    output logic [DW-1:0]                 win_hi_live,
    output logic [NUM_SYNC-1:0][DW-1:0]   hedge,
    output logic [NUM_SYNC-1:0][DW-1:0]   vline,
    output logic [NUM_SYNC-1:0][DW-1:0]   voff
);

    typedef struct packed {
        logic [DW-1:0]                               mode;
        logic [CW-1:0]                               hlen;
        logic [CW-1:0]                               vhalf;
        logic [DW-1:0]                               win_tlo;
        logic [DW-1:0]                               win_thi;
        logic [DW-1:0]                               win_blo;
        logic [DW-1:0]                               win_bhi;
        logic [NUM_SYNC-1:0][SYNC_REGS-1:0][DW-1:0]  sync;
    } regs_t;

    localparam regs_t REGS_RST = '{
        mode:    '0,
        hlen:    CW'(H_DEF),
        vhalf:   CW'(VH_DEF),
        win_tlo: '0,
        win_thi: '0,
        win_blo: '0,
        win_bhi: '0,
        sync:    '0
    };

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                AW'(ADDR_MODE):    regs_d.mode    = wr_data;
                AW'(ADDR_HLEN):    regs_d.hlen    = wr_data[CW-1:0];
                AW'(ADDR_VHALF):   regs_d.vhalf   = wr_data[CW-1:0];
                AW'(ADDR_WIN_TLO): regs_d.win_tlo = wr_data;
                AW'(ADDR_WIN_THI): regs_d.win_thi = wr_data;
                AW'(ADDR_WIN_BLO): regs_d.win_blo = wr_data;
                AW'(ADDR_WIN_BHI): regs_d.win_bhi = wr_data;
                default: ;
            endcase
            for (int k = 0; k < NUM_SYNC; k++) begin
                for (int r = 0; r < SYNC_REGS; r++) begin
                    if (wr_addr == AW'(SYNC_BASE + k * SYNC_STRIDE + r)) begin
                        regs_d.sync[k][r] = wr_data;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Restart acts on the same edge that takes the write
    assign restart     = wr_en && (wr_addr == AW'(ADDR_RESTART)) && wr_data[0];
    assign run         = (regs_q.mode == '0);
    assign hlen_live   = regs_q.hlen;
    assign vhalf_live  = regs_q.vhalf;
    assign win_lo_live = regs_q.win_tlo;
    assign win_hi_live = regs_q.win_thi;

    // Only top-field registers feed the lanes; bottom ones are storage
    for (genvar k = 0; k < NUM_SYNC; k++) begin : g_lane_regs
        assign hedge[k] = regs_q.sync[k][SREG_HEDGE];
        assign vline[k] = regs_q.sync[k][SREG_VLINE_TOP];
        assign voff[k]  = regs_q.sync[k][SREG_VOFF_TOP];
    end

endmodule

// File: rtl/raster_sync_timer.sv
module raster_sync_timer #(
    parameter int CW     = 16,
    parameter int H_DEF  = 16,
    parameter int VH_DEF = 16,
    localparam int DW    = 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [CW-1:0] hlen_live,
    input  logic [CW-1:0] vhalf_live,
    input  logic [DW-1:0] win_lo_live,
    input  logic [DW-1:0] win_hi_live,
    output logic [CW-1:0] h_cnt,
    output logic [CW-1:0] v_cnt,
    output logic [CW-1:0] hlen_sh,
    output logic [DW-1:0] win_lo_sh,
    output logic [DW-1:0] win_hi_sh,
    output logic          frame_load,
    output logic          field_evt
);

    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
        logic [CW-1:0] hlen;
        logic [CW-1:0] lines;
        logic [DW-1:0] w_lo;
        logic [DW-1:0] w_hi;
    } tim_t;

    localparam tim_t TIM_RST = '{
        h:     '0,
        v:     CW'(1),
        hlen:  CW'(H_DEF),
        lines: CW'(VH_DEF / 2),
        w_lo:  '0,
        w_hi:  '0
    };

    tim_t st_d, st_q;
    logic last_pix, last_line;

    always_comb begin
        last_pix   = ({1'b0, st_q.h} + (CW+1)'(1)) >= {1'b0, st_q.hlen};
        last_line  = st_q.v >= st_q.lines;
        frame_load = restart || (run && last_pix && last_line);

        st_d = st_q;
        if (restart) begin
            st_d.h = '0;
            st_d.v = CW'(1);
        end else if (run) begin
            if (last_pix) begin
                st_d.h = '0;
                st_d.v = last_line ? CW'(1) : st_q.v + CW'(1);
            end else begin
                st_d.h = st_q.h + CW'(1);
            end
        end

        if (frame_load) begin
            st_d.hlen  = hlen_live;
            st_d.lines = CW'(vhalf_live >> 1);
            st_d.w_lo  = win_lo_live;
            st_d.w_hi  = win_hi_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TIM_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_cnt     = st_q.h;
    assign v_cnt     = st_q.v;
    assign hlen_sh   = st_q.hlen;
    assign win_lo_sh = st_q.w_lo;
    assign win_hi_sh = st_q.w_hi;
    assign field_evt = run && (st_q.h == '0) && (st_q.v == CW'(1));

endmodule

// File: rtl/raster_sync_lane.sv
module raster_sync_lane #(
    parameter int CW  = 16,
    localparam int DW = 2 * CW
) (
    input  logic [CW-1:0] h_cnt,
    input  logic [CW-1:0] v_cnt,
    input  logic [DW-1:0] hedge,
    input  logic [DW-1:0] vline,
    input  logic [DW-1:0] voff,
    output logic          hsync,
    output logic          vsync
);

    logic [CW-1:0] hs_on, hs_off;
    logic [DW-1:0] pos, v_on, v_off;

    always_comb begin
        hs_on  = hedge[CW-1:0];
        hs_off = hedge[DW-1:CW];
        if (hs_on <= hs_off) begin
            hsync = (h_cnt >= hs_on) && (h_cnt < hs_off);
        end else begin
            hsync = (h_cnt >= hs_on) || (h_cnt < hs_off);
        end

        // Raster position ordered line first, then pixel
        pos   = {v_cnt, h_cnt};
        v_on  = {vline[CW-1:0],  voff[CW-1:0]};
        v_off = {vline[DW-1:CW], voff[DW-1:CW]};
        if (v_on <= v_off) begin
            vsync = (pos >= v_on) && (pos < v_off);
        end else begin
            vsync = (pos >= v_on) || (pos < v_off);
        end
    end

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
    parameter int CW       = 16,
    parameter int NUM_SYNC = 4,
    parameter int AW       = 8,
    parameter int H_DEF    = 16,
    parameter int VH_DEF   = 16,
    localparam int DW      = 2 * CW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    output logic [NUM_SYNC-1:0] hsync,
    output logic [NUM_SYNC-1:0] vsync,
    output logic                active,
    output logic                field_evt
);

    logic                        run, restart, frame_load;
    logic [CW-1:0]               hlen_live, vhalf_live;
    logic [DW-1:0]               win_lo_live, win_hi_live;
    logic [NUM_SYNC-1:0][DW-1:0] hedge, vline, voff;
    logic [CW-1:0]               h_cnt, v_cnt, hlen_sh;
    logic [DW-1:0]               win_lo_sh, win_hi_sh;

    raster_sync_regs #(
        .CW(CW), .NUM_SYNC(NUM_SYNC), .AW(AW), .H_DEF(H_DEF), .VH_DEF(VH_DEF)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .run         (run),
        .restart     (restart),
        .hlen_live   (hlen_live),
        .vhalf_live  (vhalf_live),
        .win_lo_live (win_lo_live),
        .win_hi_live (win_hi_live),
        .hedge       (hedge),
        .vline       (vline),
        .voff        (voff)
    );

    raster_sync_timer #(
        .CW(CW), .H_DEF(H_DEF), .VH_DEF(VH_DEF)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .restart     (restart),
        .hlen_live   (hlen_live),
        .vhalf_live  (vhalf_live),
        .win_lo_live (win_lo_live),
        .win_hi_live (win_hi_live),
        .h_cnt       (h_cnt),
        .v_cnt       (v_cnt),
        .hlen_sh     (hlen_sh),
        .win_lo_sh   (win_lo_sh),
        .win_hi_sh   (win_hi_sh),
        .frame_load  (frame_load),
        .field_evt   (field_evt)
    );

    for (genvar k = 0; k < NUM_SYNC; k++) begin : g_lane
        raster_sync_lane #(.CW(CW)) lane_i (
            .h_cnt (h_cnt),
            .v_cnt (v_cnt),
            .hedge (hedge[k]),
            .vline (vline[k]),
            .voff  (voff[k]),
            .hsync (hsync[k]),
            .vsync (vsync[k])
        );
    end

    // Window bounds inclusive on both axes
    always_comb begin
        active = (v_cnt >= win_lo_sh[DW-1:CW]) && (v_cnt <= win_hi_sh[DW-1:CW]) &&
                 (h_cnt >= win_lo_sh[CW-1:0])  && (h_cnt <= win_hi_sh[CW-1:0]);
    end

endmodule

// File: rtl/raster_sync_chk.sv
module raster_sync_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          restart,
    input logic          frame_load,
    input logic          field_evt,
    input logic [CW-1:0] h_cnt,
    input logic [CW-1:0] v_cnt,
    input logic [CW-1:0] hlen_sh
);

    p_hcnt_below_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hlen_sh != '0) |-> (h_cnt < hlen_sh));

    p_vcnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v_cnt != '0);

    p_restart_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (h_cnt == '0) && (v_cnt == CW'(1)));

    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> ($stable(h_cnt) && $stable(v_cnt)));

    p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (field_evt && !restart && (hlen_sh > CW'(1))) |=> !field_evt);

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(hlen_sh));

endmodule

bind raster_sync_gen raster_sync_chk #(.CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .restart    (restart),
    .frame_load (frame_load),
    .field_evt  (field_evt),
    .h_cnt      (h_cnt),
    .v_cnt      (v_cnt),
    .hlen_sh    (hlen_sh)
);

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb_top;

    localparam int CW = 16;
    localparam int NS = 4;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int HDEF = 16;
    localparam int VHDEF = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NS-1:0] hsync, vsync;
    logic          active, field_evt;

    always #2 clk = ~clk;

    raster_sync_gen #(
        .CW(CW), .NUM_SYNC(NS), .AW(AW), .H_DEF(HDEF), .VH_DEF(VHDEF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .active(active), .field_evt(field_evt)
    );

    typedef struct {
        logic [NS-1:0] hs;
        logic [NS-1:0] vs;
        logic          act;
        logic          evt;
        string         req;
    } exp_t;

    exp_t  sb_q[$];
    string phase = "R1";
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    // Reference state from the requirements
    int          mh, mv, mL, mLines, lL, lHalf;
    logic [31:0] mw0, mw1, lw0, lw1, lmode;
    logic [31:0] lsync [NS][5];
    bit          m_rs, m_load;

    function automatic bit in_span(int p, int a, int b, int m);
        int da, db;
        if (m <= 0) return 0;
        da = ((p - a) % m + m) % m;
        db = ((b - a) % m + m) % m;
        return da < db;
    endfunction

    function automatic exp_t make_exp();
        exp_t e;
        int p, a, b, fr;
        for (int k = 0; k < NS; k++) begin
            e.hs[k] = in_span(mh, int'(lsync[k][0][15:0]), int'(lsync[k][0][31:16]), mL);
            p  = (mv - 1) * mL + mh;
            a  = (int'(lsync[k][1][15:0]) - 1) * mL + int'(lsync[k][3][15:0]);
            b  = (int'(lsync[k][1][31:16]) - 1) * mL + int'(lsync[k][3][31:16]);
            fr = mLines * mL;
            e.vs[k] = in_span(p, a, b, fr);
        end
        e.act = (mv >= int'(mw0[31:16])) && (mv <= int'(mw1[31:16])) &&
                (mh >= int'(mw0[15:0]))  && (mh <= int'(mw1[15:0]));
        e.evt = (lmode == 0) && (mh == 0) && (mv == 1);
        e.req = phase;
        return e;
    endfunction

    // Driver side of the scoreboard: advance the model, push expectation
    always @(posedge clk) begin
        if (!rst_n) begin
            mh = 0; mv = 1; mL = HDEF; mLines = VHDEF / 2;
            lL = HDEF; lHalf = VHDEF; lmode = 0;
            mw0 = 0; mw1 = 0; lw0 = 0; lw1 = 0;
            for (int k = 0; k < NS; k++)
                for (int r = 0; r < 5; r++) lsync[k][r] = 0;
        end else begin
            m_rs = wr_en && (wr_addr == 8'h03) && wr_data[0];
            m_load = 0;
            if (m_rs) begin
                mh = 0; mv = 1; m_load = 1;
            end else if (lmode == 0) begin
                if (mh + 1 >= mL) begin
                    mh = 0;
                    if (mv >= mLines) begin mv = 1; m_load = 1; end
                    else mv = mv + 1;
                end else begin
                    mh = mh + 1;
                end
            end
            if (m_load) begin
                mL = lL; mLines = lHalf / 2; mw0 = lw0; mw1 = lw1;
            end
            if (wr_en) begin
                case (wr_addr)
                    8'h00: lmode = wr_data;
                    8'h01: lL = int'(wr_data[15:0]);
                    8'h02: lHalf = int'(wr_data[15:0]);
                    8'h04: lw0 = wr_data;
                    8'h05: lw1 = wr_data;
                    default: ;
                endcase
                if (wr_addr >= 8'h10 && wr_addr < 8'h30 && ((wr_addr - 8'h10) % 8) < 5)
                    lsync[(wr_addr - 8'h10) / 8][(wr_addr - 8'h10) % 8] = wr_data;
            end
        end
        sb_q.push_back(make_exp());
    end

    // Monitor side: pop and compare away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0 && !done) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (hsync !== e.hs || vsync !== e.vs || active !== e.act || field_evt !== e.evt) begin
                failures++;
                $display("FAIL %s t=%0t hsync=%b/%b vsync=%b/%b active=%b/%b field_evt=%b/%b (actual/expected)",
                         e.req, $time, hsync, e.hs, vsync, e.vs, active, e.act, field_evt, e.evt);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        // R2: default counting
        phase = "R2 default counting";
        idle(20);
        // R12 R8: new lengths and window, shadowed until frame wrap
        phase = "R8 R12 shadowed setup";
        wr('h01, 12);
        wr('h02, 12);
        wr('h04, (32'd2 << 16) | 32'd3);
        wr('h05, (32'd4 << 16) | 32'd8);
        idle(140);
        // R3 R4 R5: per-lane placements
        phase = "R3 R4 R5 lane placement";
        wr('h10, (32'd5 << 16) | 32'd2);   // lane0 plain
        wr('h18, (32'd3 << 16) | 32'd10);  // lane1 wraps line end
        wr('h20, (32'd7 << 16) | 32'd7);   // lane2 zero width
        wr('h21, (32'd2 << 16) | 32'd1);   // lane2 vsync line 1 -> 2
        wr('h23, (32'd5 << 16) | 32'd5);   // mid-line offsets
        wr('h28, (32'd11 << 16) | 32'd0);  // lane3 hsync
        wr('h29, (32'd1 << 16) | 32'd6);   // lane3 wraps frame end
        wr('h2B, (32'd4 << 16) | 32'd9);
        idle(80);
        // R9 R7: restart and field events
        phase = "R9 R7 restart";
        wr('h03, 1);
        idle(200);
        // R11: bottom registers ignored
        phase = "R11 bottom ignored";
        wr('h06, (32'd1 << 16) | 32'd0);
        wr('h07, (32'd6 << 16) | 32'd11);
        wr('h12, (32'd3 << 16) | 32'd2);
        wr('h14, (32'd6 << 16) | 32'd1);
        wr('h2A, (32'd5 << 16) | 32'd1);
        idle(80);
        // R8: mid-frame length changes
        phase = "R8 mid-frame lengths";
        idle(17);
        wr('h01, 14);
        idle(30);
        wr('h29, (32'd1 << 16) | 32'd4);
        wr('h02, 8);
        idle(200);
        // R10: freeze and resume
        phase = "R10 freeze";
        idle(5);
        wr('h00, 1);
        idle(40);
        wr('h00, 0);
        idle(60);
        // R9: restart bit clear is ignored, then real restarts
        phase = "R9 restart bit0 clear";
        wr('h03, 32'hFFFF_FFFE);
        idle(10);
        phase = "R9 R7 restart mid-line";
        wr('h03, 1);
        idle(5);
        wr('h03, 1);
        idle(100);
        // R6: window covering the full frame, bounds inclusive
        phase = "R6 window bounds";
        wr('h04, (32'd1 << 16) | 32'd0);
        wr('h05, (32'd4 << 16) | 32'd13);
        wr('h03, 1);
        idle(80);
        wr('h04, (32'd3 << 16) | 32'd13);
        wr('h05, (32'd3 << 16) | 32'd13);
        wr('h03, 1);
        idle(80);
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule